// File: doc/BRIEF.md
# Status Flag Register with Branch Condition Evaluator

This block keeps the four arithmetic status flags of a processor: negative, zero, overflow and carry. The flags an ALU produces for the current instruction are captured only when that instruction asks for it through a per-instruction write enable. Instructions that leave the enable low pass through without disturbing the stored flags. A later branch can therefore test the outcome of any earlier flag-writing instruction, even when other work lies between the two.

Next to the register sits a condition evaluator. It takes a 4-bit condition selector from the branch instruction and tests it against the stored flags. It returns a single taken bit. The sixteen conditions are: unconditional, never, single-flag tests, and the signed and unsigned magnitude comparisons. They are encoded as complementary pairs, so bit 0 of the selector always inverts the outcome of the pair. Target address computation and program counter update are left to the surrounding pipeline.

Top module: `cc_branch_unit`

## Requirements
- R1: While reset is asserted, and after it is released, all four stored flags read 0 until the first enabled write.
- R2: When the flag write enable is high at a rising clock edge, the flag inputs are captured and appear on `flags_o` after that edge, with bit order {N, Z, V, C} on bits 3 down to 0.
- R3: When the flag write enable is low at a rising clock edge, `flags_o` keeps its previous value whatever the flag inputs are.
- R4: `taken_o` depends only on the stored flags and `cond_i`, so a branch evaluated in the same cycle as a flag write sees the flags from before that write.
- R5: Selector 4'h0 is always taken and 4'h1 is never taken, whatever the flags are.
- R6: Selector 4'h2 is taken when Z=1 and 4'h3 when Z=0. 4'h4 is taken when C=1 and 4'h5 when C=0. 4'h6 is taken when N=1 and 4'h7 when N=0. 4'h8 is taken when V=1 and 4'h9 when V=0.
- R7: Selector 4'hA (signed less) is taken when N xor V is 1. 4'hB (signed greater-or-equal) is taken when N xor V is 0.
- R8: Selector 4'hC (signed less-or-equal) is taken when Z or (N xor V) is 1. 4'hD (signed greater) is taken when that term is 0.
- R9: Selector 4'hE (unsigned less-or-equal) is taken when C or Z is 1. 4'hF (unsigned greater) is taken when that term is 0.
- R10: For every even selector k, selector k+1 gives the complement of the result of k under the same flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_flags_i | input | 1 | Flag write enable for the current instruction |
| alu_n_i | input | 1 | Negative flag from the ALU |
| alu_z_i | input | 1 | Zero flag from the ALU |
| alu_v_i | input | 1 | Overflow flag from the ALU |
| alu_c_i | input | 1 | Carry flag from the ALU |
| cond_i | input | 4 | Branch condition selector |
| flags_o | output | 4 | Stored flags {N, Z, V, C} |
| taken_o | output | 1 | Branch condition result |

## Verification
Each selector is first applied under all sixteen flag combinations. This separates conditions that share a flag, such as signed less against signed less-or-equal, which differ only when Z is set, and unsigned less-or-equal against carry set, which differ when Z=1 and C=0. Random sequences then mix enabled and disabled writes with random selectors, and each selector is checked in the same cycle as a possible write. This tells a correct design apart from one that holds the flags wrongly or lets the branch see the new flags too early.

// File: rtl/cc_pkg.sv
package cc_pkg;
    localparam int NUM_FLAGS = 4;
    localparam int COND_W    = 4;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    typedef enum logic [COND_W-1:0] {
        C_ALWAYS = 4'h0, C_NEVER = 4'h1,
        C_ZSET   = 4'h2, C_ZCLR  = 4'h3,
        C_CSET   = 4'h4, C_CCLR  = 4'h5,
        C_NSET   = 4'h6, C_NCLR  = 4'h7,
        C_VSET   = 4'h8, C_VCLR  = 4'h9,
        C_SLT    = 4'hA, C_SGE   = 4'hB,
        C_SLE    = 4'hC, C_SGT   = 4'hD,
        C_ULE    = 4'hE, C_UGT   = 4'hF
    } cond_e;

    typedef struct packed {
        flags_t flags;
    } ccr_state_t;
endpackage

// File: rtl/cc_flag_reg.sv
module cc_flag_reg
    import cc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr_en,
    input  flags_t wr_flags,
    output flags_t flags_q
);
    ccr_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            state_d.flags = wr_flags;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign flags_q = state_q.flags;

    AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (flags_q == $past(wr_flags))); // R2
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(flags_q)); // R3
endmodule

// File: rtl/cc_cond_eval.sv
module cc_cond_eval
    import cc_pkg::*;
(
    input  flags_t            flags,
    input  logic [COND_W-1:0] cond,
    output logic              taken
);
    localparam int NUM_PAIRS = (1 << COND_W) / 2;

    logic [NUM_PAIRS-1:0] pair_base;
    logic                 slt;

    assign slt = flags.n ^ flags.v;

    // positive sense of each complementary pair; index = cond[3:1]
    always_comb begin
        pair_base[0] = 1'b1;
        pair_base[1] = flags.z;
        pair_base[2] = flags.c;
        pair_base[3] = flags.n;
        pair_base[4] = flags.v;
        pair_base[5] = slt;
        pair_base[6] = flags.z | slt;
        pair_base[7] = flags.c | flags.z;
    end

    assign taken = pair_base[cond[COND_W-1:1]] ^ cond[0];

    always_comb begin
        if (cond == C_ALWAYS) AST_ALWAYS_TAKEN: assert (taken); // R5
        if (cond == C_NEVER)  AST_NEVER_TAKEN:  assert (!taken); // R5
        if (cond == C_UGT && flags.c) AST_UGT_CARRY: assert (!taken); // R9
        if (cond == C_SLE && flags.z) AST_SLE_ZERO:  assert (taken); // R8
    end
endmodule

// File: rtl/cc_branch_unit.sv
module cc_branch_unit
    import cc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_flags_i,
    input  logic              alu_n_i,
    input  logic              alu_z_i,
    input  logic              alu_v_i,
    input  logic              alu_c_i,
    input  logic [COND_W-1:0] cond_i,
    output logic [NUM_FLAGS-1:0] flags_o,
    output logic              taken_o
);
    flags_t in_flags, stored;

    assign in_flags = '{n: alu_n_i, z: alu_z_i, v: alu_v_i, c: alu_c_i};

    cc_flag_reg u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (set_flags_i),
        .wr_flags (in_flags),
        .flags_q  (stored)
    );

    cc_cond_eval u_eval (
        .flags (stored),
        .cond  (cond_i),
        .taken (taken_o)
    );

    assign flags_o = stored;

    AST_BRANCH_OLD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_flags_i && cond_i == C_ZSET) |-> (taken_o == flags_o[2])); // R4
endmodule

// File: tb/tb_cc_branch_unit.sv
`timescale 1ns/1ps
module tb_cc_branch_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       set_flags_i = 1'b0;
    logic       alu_n_i = 1'b0, alu_z_i = 1'b0, alu_v_i = 1'b0, alu_c_i = 1'b0;
    logic [3:0] cond_i = 4'h0;
    logic [3:0] flags_o;
    logic       taken_o;

    int n_checks = 0;
    int n_fail = 0;
    logic [3:0] model = 4'h0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cc_branch_unit dut (
        .clk(clk), .rst_n(rst_n), .set_flags_i(set_flags_i),
        .alu_n_i(alu_n_i), .alu_z_i(alu_z_i), .alu_v_i(alu_v_i), .alu_c_i(alu_c_i),
        .cond_i(cond_i), .flags_o(flags_o), .taken_o(taken_o)
    );

    // f = {N,Z,V,C}
    function automatic logic exp_taken(input logic [3:0] f, input logic [3:0] c);
        logic n, z, v, cy, r;
        n = f[3]; z = f[2]; v = f[1]; cy = f[0];
        case (c)
            4'h0: r = 1'b1;          4'h1: r = 1'b0;
            4'h2: r = z;             4'h3: r = !z;
            4'h4: r = cy;            4'h5: r = !cy;
            4'h6: r = n;             4'h7: r = !n;
            4'h8: r = v;             4'h9: r = !v;
            4'hA: r = n ^ v;         4'hB: r = !(n ^ v);
            4'hC: r = z | (n ^ v);   4'hD: r = !(z | (n ^ v));
            4'hE: r = cy | z;        4'hF: r = !(cy | z);
            default: r = 1'b0;
        endcase
        return r;
    endfunction

    function automatic string tag_of(input logic [3:0] c);
        if (c <= 4'h1) return "R5";
        if (c <= 4'h9) return "R6";
        if (c <= 4'hB) return "R7";
        if (c <= 4'hD) return "R8";
        return "R9";
    endfunction

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic set, input logic [3:0] f, input logic [3:0] c);
        set_flags_i = set;
        {alu_n_i, alu_z_i, alu_v_i, alu_c_i} = f;
        cond_i = c;
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hang expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        // R1: reset state, inputs driven to ones while in reset
        drive(1'b1, 4'hF, 4'h0);
        repeat (3) @(negedge clk);
        check("R1", flags_o, 4'h0);
        rst_n = 1'b1;
        drive(1'b0, 4'hF, 4'h0);
        @(negedge clk);
        check("R1", flags_o, 4'h0);

        // directed: every flag pattern against every selector (R5..R10)
        for (int f = 0; f < 16; f++) begin
            drive(1'b1, f[3:0], 4'h0);
            @(posedge clk); model = f[3:0];
            @(negedge clk);
            check("R2", flags_o, model);
            drive(1'b0, ~f[3:0], 4'h0);
            for (int c = 0; c < 16; c++) begin
                cond_i = c[3:0];
                #1;
                check(tag_of(c[3:0]), {3'b0, taken_o}, {3'b0, exp_taken(model, c[3:0])});
                if (c[0]) begin
                    // R10: odd selector is the complement of its even partner
                    check("R10", {3'b0, taken_o}, {3'b0, !exp_taken(model, c[3:0] - 4'h1)});
                end
            end
            @(posedge clk);
            @(negedge clk);
            check("R3", flags_o, model);
        end

        // R4: same-cycle write, branch sees old flags
        drive(1'b1, 4'h0, 4'h0);
        @(posedge clk); model = 4'h0;
        @(negedge clk);
        drive(1'b1, 4'b0100, 4'h2);
        #1;
        check("R4", {3'b0, taken_o}, 4'h0);
        @(posedge clk); model = 4'b0100;
        @(negedge clk);
        #1;
        check("R4", {3'b0, taken_o}, 4'h1);

        // random mix
        for (int i = 0; i < 2000; i++) begin
            logic s;
            logic [3:0] fv, cv;
            s  = ($urandom % 3) == 0;
            fv = 4'($urandom);
            cv = 4'($urandom);
            drive(s, fv, cv);
            #1;
            check(s ? "R4" : tag_of(cv), {3'b0, taken_o}, {3'b0, exp_taken(model, cv)});
            @(posedge clk);
            if (s) model = fv;
            @(negedge clk);
            check(s ? "R2" : "R3", flags_o, model);
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule